// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block decides whether a memory access may use a leaf translation entry that a table walker has already fetched. It takes the 64-bit leaf entry, the kind of access (load, store or instruction fetch), the problem-state flag, a flag that says the check belongs to the partition-scoped stage, and a 3-bit read/write/execute mask from the authority-mask register. From these it works out which permissions are granted and whether the access takes a protection fault. When protection passes, it also checks that the entry's reference and change bits already suit the access. It then forms the cause word that the fault path would record.

The walker presents one entry per cycle, qualified by a valid strobe. One cycle later the block returns the result with its own valid. All flags and words are forced to zero while that valid is low, so the fault path can OR them in without gating.

Top module: `leaf_access_checker`

## Requirements
- R1: While reset is asserted, and until the first accepted request, `out_valid`, `grant_perm`, `prot_fault`, `rc_update`, `data_cause` and `insn_cause` are all zero.
- R2: A request with `req_valid` high in one cycle produces `out_valid` high in the next cycle. A cycle without a request produces `out_valid` low in the next cycle, with every other output zero.
- R3: For an instruction fetch (`acc_type` = 2) of an entry whose attribute field `pte[5:4]` equals 2'b11 (non-idempotent I/O), the block reports a protection fault, grants nothing and sets the guard cause bit 28 in `insn_cause`. The permission bits, the authority mask and the privilege settings do not change this result.
- R4: For a process-scoped check (`part_scoped` = 0) of a privileged entry (`pte[3]` = 1) made in problem state (`prob_state` = 1), the granted mask is empty.
- R5: In every other case the granted mask {read, write, execute} is {`pte[2]`, `pte[1]`, `pte[0]`}. The authority mask `amr_perm` (bit 2 read, bit 1 write, bit 0 execute) is ANDed in only for a process-scoped check of a non-privileged entry made in privileged state.
- R6: A load (`acc_type` 0 or 3) needs read, a store (`acc_type` 1) needs write, and a fetch (`acc_type` 2) needs execute. If the needed bit is missing from the granted mask, `prot_fault` is raised. A fetch then sets bit 28 of `insn_cause`, and a load or store sets bit 27 of `data_cause`.
- R7: If there is no protection fault, a store with either the reference bit `pte[8]` or the change bit `pte[7]` clear raises `rc_update`. A load or fetch with the reference bit clear also raises `rc_update`. In both cases bit 21 is set in the cause word. `rc_update` and `prot_fault` are never high together.
- R8: A load or store that reports any fault leaves `insn_cause` zero. A store that reports any fault also sets bit 25 of `data_cause`. A fetch always leaves `data_cause` zero.
- R9: An access with no protection fault and no reference/change problem returns both cause words as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| pte | input | 64 | Leaf translation entry |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| prob_state | input | 1 | Access made in problem (user) state |
| part_scoped | input | 1 | Check belongs to the partition-scoped stage |
| amr_perm | input | 3 | Authority-mask permissions {read, write, execute} |
| out_valid | output | 1 | Result valid |
| grant_perm | output | 3 | Granted permissions {read, write, execute} |
| prot_fault | output | 1 | Protection or guard fault |
| rc_update | output | 1 | Reference/change update needed |
| data_cause | output | 32 | Cause word for a data storage fault |
| insn_cause | output | 32 | Cause code for an instruction storage fault |

## Verification
The assertions check on every cycle that results appear one cycle after each request and that idle outputs stay zero. They also check that a guarded fetch always faults, that a privileged page in problem state grants nothing, and that grants never exceed the entry's bits. Finally, they check that a fault and an RC request never occur together and that the store bit and the fetch/data split follow the access type. The exact grant when the authority mask is applied, the choice between the protection and guard bits, and the RC pass/fail rule per access type can only be shown by the bench. Its reference model is compared with the outputs on every clock, over directed corner cases and a long stream of random entries.

// File: rtl/leaf_chk_pkg.sv
`timescale 1ns/1ps
package leaf_chk_pkg;

  localparam int ENTRY_W = 64;
  localparam int CAUSE_W = 32;
  localparam int PERM_W  = 3;

  // permission vector positions
  localparam int PERM_R = 2;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 0;

  // entry field positions
  localparam int ENT_X_BIT    = 0;
  localparam int ENT_W_BIT    = 1;
  localparam int ENT_R_BIT    = 2;
  localparam int ENT_PRIV_BIT = 3;
  localparam int ENT_ATT_LO   = 4;
  localparam int ENT_ATT_W    = 2;
  localparam int ENT_CHG_BIT  = 7;
  localparam int ENT_REF_BIT  = 8;

  localparam logic [ENT_ATT_W-1:0] ATT_NONIDEM_IO = 2'b11;

  // cause word positions
  localparam int CZ_GUARD = 28;
  localparam int CZ_PROT  = 27;
  localparam int CZ_STORE = 25;
  localparam int CZ_RC    = 21;

  typedef logic [PERM_W-1:0] perm_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

endpackage

// File: rtl/lc_rst_sync.sv
`timescale 1ns/1ps
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lc_perm_eval.sv
`timescale 1ns/1ps
module lc_perm_eval
  import leaf_chk_pkg::*;
#(
  parameter int PTE_W = ENTRY_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic             prob_state,
  input  logic             part_scoped,
  input  perm_t            amr,
  output perm_t            grant,
  output logic             guard_hit,
  output logic             perm_miss
);

  perm_t eaa;
  perm_t need;
  perm_t miss_bits;
  logic  priv_page;
  logic  priv_blocked;
  logic  amr_apply;
  logic  is_fetch;

  always_comb begin
    eaa[PERM_R]     = pte[ENT_R_BIT];
    eaa[PERM_W_BIT] = pte[ENT_W_BIT];
    eaa[PERM_X]     = pte[ENT_X_BIT];
    priv_page       = pte[ENT_PRIV_BIT];
    is_fetch        = (acc == ACC_FETCH);
    guard_hit       = is_fetch &&
                      (pte[ENT_ATT_LO +: ENT_ATT_W] == ATT_NONIDEM_IO);
    priv_blocked    = !part_scoped && priv_page && prob_state;
    amr_apply       = !part_scoped && !priv_page && !prob_state;
  end

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[PERM_W_BIT] = 1'b1;
      ACC_FETCH: need[PERM_X]     = 1'b1;
      default:   need[PERM_R]     = 1'b1;
    endcase
  end

  for (genvar gi = 0; gi < PERM_W; gi++) begin : g_bit
    always_comb begin
      if (guard_hit || priv_blocked) begin
        grant[gi] = 1'b0;
      end else if (amr_apply) begin
        grant[gi] = eaa[gi] & amr[gi];
      end else begin
        grant[gi] = eaa[gi];
      end
      miss_bits[gi] = need[gi] & ~grant[gi];
    end
  end

  assign perm_miss = !guard_hit && (|miss_bits);

endmodule

// File: rtl/lc_rc_eval.sv
`timescale 1ns/1ps
module lc_rc_eval
  import leaf_chk_pkg::*;
#(
  parameter int PTE_W = ENTRY_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  output logic             rc_miss
);

  logic ref_set;
  logic chg_set;

  always_comb begin
    ref_set = pte[ENT_REF_BIT];
    chg_set = pte[ENT_CHG_BIT];
    if (acc == ACC_STORE) begin
      rc_miss = !(ref_set && chg_set);
    end else begin
      rc_miss = !ref_set;
    end
  end

endmodule

// File: rtl/lc_cause_build.sv
`timescale 1ns/1ps
module lc_cause_build
  import leaf_chk_pkg::*;
#(
  parameter int CW = CAUSE_W
) (
  input  logic [1:0]    acc,
  input  logic          guard_hit,
  input  logic          perm_miss,
  input  logic          rc_miss,
  output logic          fault,
  output logic          rc_fail,
  output logic [CW-1:0] dcause,
  output logic [CW-1:0] icause
);

  logic          is_fetch;
  logic          is_store;
  logic [CW-1:0] base;

  always_comb begin
    is_fetch = (acc == ACC_FETCH);
    is_store = (acc == ACC_STORE);
    fault    = guard_hit || perm_miss;
    rc_fail  = !fault && rc_miss;

    base = '0;
    if (guard_hit || (perm_miss && is_fetch)) begin
      base[CZ_GUARD] = 1'b1;
    end
    if (perm_miss && !is_fetch) begin
      base[CZ_PROT] = 1'b1;
    end
    if (rc_fail) begin
      base[CZ_RC] = 1'b1;
    end

    if (is_fetch) begin
      icause = base;
      dcause = '0;
    end else begin
      icause = '0;
      dcause = base;
      if (is_store && (fault || rc_fail)) begin
        dcause[CZ_STORE] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/leaf_access_checker.sv
`timescale 1ns/1ps
module leaf_access_checker
  import leaf_chk_pkg::*;
#(
  parameter int PTE_W   = ENTRY_W,
  parameter int CW      = CAUSE_W,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc_type,
  input  logic             prob_state,
  input  logic             part_scoped,
  input  logic [2:0]       amr_perm,
  output logic             out_valid,
  output logic [2:0]       grant_perm,
  output logic             prot_fault,
  output logic             rc_update,
  output logic [CW-1:0]    data_cause,
  output logic [CW-1:0]    insn_cause
);

  logic rst_sync_n;

  perm_t         grant_c;
  logic          guard_c;
  logic          pmiss_c;
  logic          rcmiss_c;
  logic          fault_c;
  logic          rcfail_c;
  logic [CW-1:0] dcause_c;
  logic [CW-1:0] icause_c;

  logic          vld_q,    vld_d;
  perm_t         grant_q,  grant_d;
  logic          fault_q,  fault_d;
  logic          rc_q,     rc_d;
  logic [CW-1:0] dcause_q, dcause_d;
  logic [CW-1:0] icause_q, icause_d;
  logic          cap_en;

  lc_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lc_perm_eval #(.PTE_W(PTE_W)) u_perm (
    .pte         (pte),
    .acc         (acc_type),
    .prob_state  (prob_state),
    .part_scoped (part_scoped),
    .amr         (amr_perm),
    .grant       (grant_c),
    .guard_hit   (guard_c),
    .perm_miss   (pmiss_c)
  );

  lc_rc_eval #(.PTE_W(PTE_W)) u_rc (
    .pte     (pte),
    .acc     (acc_type),
    .rc_miss (rcmiss_c)
  );

  lc_cause_build #(.CW(CW)) u_cause (
    .acc       (acc_type),
    .guard_hit (guard_c),
    .perm_miss (pmiss_c),
    .rc_miss   (rcmiss_c),
    .fault     (fault_c),
    .rc_fail   (rcfail_c),
    .dcause    (dcause_c),
    .icause    (icause_c)
  );

  // next-state
  always_comb begin
    cap_en   = req_valid;
    vld_d    = req_valid;
    grant_d  = grant_q;
    fault_d  = fault_q;
    rc_d     = rc_q;
    dcause_d = dcause_q;
    icause_d = icause_q;
    if (cap_en) begin
      grant_d  = grant_c;
      fault_d  = fault_c;
      rc_d     = rcfail_c;
      dcause_d = dcause_c;
      icause_d = icause_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q    <= 1'b0;
      grant_q  <= '0;
      fault_q  <= 1'b0;
      rc_q     <= 1'b0;
      dcause_q <= '0;
      icause_q <= '0;
    end else begin
      vld_q    <= vld_d;
      grant_q  <= grant_d;
      fault_q  <= fault_d;
      rc_q     <= rc_d;
      dcause_q <= dcause_d;
      icause_q <= icause_d;
    end
  end

  // outputs qualified by valid
  always_comb begin
    out_valid  = vld_q;
    grant_perm = vld_q ? grant_q : '0;
    prot_fault = vld_q && fault_q;
    rc_update  = vld_q && rc_q;
    data_cause = vld_q ? dcause_q : '0;
    insn_cause = vld_q ? icause_q : '0;
  end

endmodule

// File: rtl/leaf_access_checker_sva.sv
`timescale 1ns/1ps
module leaf_access_checker_sva
  import leaf_chk_pkg::*;
#(
  parameter int PTE_W = ENTRY_W,
  parameter int CW    = CAUSE_W
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             req_valid,
  input logic [PTE_W-1:0] pte,
  input logic [1:0]       acc_type,
  input logic             prob_state,
  input logic             part_scoped,
  input logic             out_valid,
  input logic [2:0]       grant_perm,
  input logic             prot_fault,
  input logic             rc_update,
  input logic [CW-1:0]    data_cause,
  input logic [CW-1:0]    insn_cause
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_valid |-> (grant_perm == 3'b000 && !prot_fault && !rc_update &&
                    data_cause == '0 && insn_cause == '0)); // R2

  AST_GUARD_FETCH: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && acc_type == ACC_FETCH &&
     pte[ENT_ATT_LO +: ENT_ATT_W] == ATT_NONIDEM_IO)
    |=> (prot_fault && insn_cause[CZ_GUARD] && grant_perm == 3'b000)); // R3

  AST_PRIV_EMPTY: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !part_scoped && pte[ENT_PRIV_BIT] && prob_state)
    |=> (grant_perm == 3'b000)); // R4

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> ((grant_perm & ~{$past(pte[ENT_R_BIT]), $past(pte[ENT_W_BIT]),
                                   $past(pte[ENT_X_BIT])}) == 3'b000)); // R5

  AST_FAULT_RC_EXCL: assert property (@(posedge clk) disable iff (!rst_ok)
    !(prot_fault && rc_update)); // R7

  AST_FETCH_NO_DATA: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && acc_type == ACC_FETCH) |=> (data_cause == '0)); // R8

  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && acc_type == ACC_STORE)
    |=> (data_cause[CZ_STORE] == (prot_fault || rc_update))); // R8

  AST_DATA_NO_INSN: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && acc_type != ACC_FETCH) |=> (insn_cause == '0)); // R8

endmodule

bind leaf_access_checker leaf_access_checker_sva #(.PTE_W(PTE_W), .CW(CW)) i_sva (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .req_valid   (req_valid),
  .pte         (pte),
  .acc_type    (acc_type),
  .prob_state  (prob_state),
  .part_scoped (part_scoped),
  .out_valid   (out_valid),
  .grant_perm  (grant_perm),
  .prot_fault  (prot_fault),
  .rc_update   (rc_update),
  .data_cause  (data_cause),
  .insn_cause  (insn_cause)
);

// File: tb/test_leaf_access_checker.sv
`timescale 1ns/1ps
module test_leaf_access_checker;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] pte;
  logic [1:0]  acc_type;
  logic        prob_state;
  logic        part_scoped;
  logic [2:0]  amr_perm;
  logic        out_valid;
  logic [2:0]  grant_perm;
  logic        prot_fault;
  logic        rc_update;
  logic [31:0] data_cause;
  logic [31:0] insn_cause;

  int checks = 0;
  int fails  = 0;
  bit run_chk = 0;
  bit done = 0;
  string cur_tag = "reset";

  logic        e_valid;
  logic [2:0]  e_grant;
  logic        e_fault;
  logic        e_rc;
  logic [31:0] e_dc;
  logic [31:0] e_ic;

  leaf_access_checker i_leaf_access_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte(pte),
    .acc_type(acc_type), .prob_state(prob_state), .part_scoped(part_scoped),
    .amr_perm(amr_perm), .out_valid(out_valid), .grant_perm(grant_perm),
    .prot_fault(prot_fault), .rc_update(rc_update),
    .data_cause(data_cause), .insn_cause(insn_cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual %h expected %h", req, cur_tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int att, input int priv, input int r,
                                     input int w, input int x, input int rf, input int ch);
    logic [63:0] p;
    p = 64'h0;
    p[5:4] = att[1:0];
    p[3] = priv[0];
    p[2] = r[0];
    p[1] = w[0];
    p[0] = x[0];
    p[8] = rf[0];
    p[7] = ch[0];
    p[63:12] = 52'h00ABC_DEF01;
    return p;
  endfunction

  // behavioural reference model
  task automatic model(input logic [63:0] p, input logic [1:0] a, input logic pr,
                       input logic pt, input logic [2:0] am,
                       output logic [2:0] g, output logic pf, output logic rc,
                       output logic [31:0] dc, output logic [31:0] ic);
    bit fetch, store, fault, rcbad;
    int need;
    logic [31:0] c;
    fetch = (a == 2);
    store = (a == 1);
    c = 0;
    fault = 0;
    rcbad = 0;
    if (fetch) need = 1; else if (store) need = 2; else need = 4;
    if (fetch && p[5:4] == 2'b11) begin
      g = 3'b000;
      fault = 1;
      c = 32'h1000_0000;
    end else begin
      if (!pt && p[3] && pr) g = 3'b000;
      else if (!pt && !p[3] && !pr) g = p[2:0] & am;
      else g = p[2:0];
      if ((need & ~int'(g)) != 0) begin
        fault = 1;
        c = fetch ? 32'h1000_0000 : 32'h0800_0000;
      end else begin
        if (store) rcbad = !(p[8] && p[7]);
        else rcbad = !p[8];
        if (rcbad) c = 32'h0020_0000;
      end
    end
    pf = fault;
    rc = rcbad;
    if (fetch) begin
      ic = c;
      dc = 0;
    end else begin
      ic = 0;
      dc = c;
      if (store && (fault || rcbad)) dc = dc | 32'h0200_0000;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      e_valid = 0; e_grant = 0; e_fault = 0; e_rc = 0; e_dc = 0; e_ic = 0;
    end else begin
      e_valid = 1;
      model(pte, acc_type, prob_state, part_scoped, amr_perm,
            e_grant, e_fault, e_rc, e_dc, e_ic);
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      chk("R2 valid", {31'b0, out_valid}, {31'b0, e_valid});
      chk("R5 grant", {29'b0, grant_perm}, {29'b0, e_grant});
      chk("R6 prot_fault", {31'b0, prot_fault}, {31'b0, e_fault});
      chk("R7 rc_update", {31'b0, rc_update}, {31'b0, e_rc});
      chk("R8 data_cause", data_cause, e_dc);
      chk("R8 insn_cause", insn_cause, e_ic);
    end
  end

  task automatic send(input string tag, input logic [63:0] p, input logic [1:0] a,
                      input logic pr, input logic pt, input logic [2:0] am);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; pte = p; acc_type = a; prob_state = pr;
    part_scoped = pt; amr_perm = am;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 0;
    pte = 64'hFFFF_FFFF_FFFF_FFFF;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; pte = 0; acc_type = 0;
    prob_state = 0; part_scoped = 0; amr_perm = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'b0, out_valid}, 0);
    chk("R1 flags", {30'b0, prot_fault, rc_update}, 0);
    chk("R1 causes", data_cause | insn_cause | {29'b0, grant_perm}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_chk = 1;

    // R3 guard fetch overrides full permissions
    send("R3 guard fetch", mk(3, 0, 1, 1, 1, 1, 1), 2, 0, 1, 3'b111);
    send("R3 guard fetch priv", mk(3, 1, 1, 1, 1, 1, 1), 2, 1, 0, 3'b000);
    send("R3 guard attr load ok", mk(3, 0, 1, 1, 1, 1, 1), 0, 1, 0, 3'b000);
    idle("R2 idle");
    // R4 privileged page in problem state
    send("R4 priv prob load", mk(0, 1, 1, 1, 1, 1, 1), 0, 1, 0, 3'b111);
    send("R4 priv prob part-scoped", mk(0, 1, 1, 1, 1, 1, 1), 0, 1, 1, 3'b000);
    // R5 authority mask intersection
    send("R5 amr applied", mk(0, 0, 1, 1, 0, 1, 1), 0, 0, 0, 3'b010);
    send("R5 amr not for prob", mk(0, 0, 1, 1, 0, 1, 1), 0, 1, 0, 3'b000);
    send("R5 amr not for priv page", mk(0, 1, 1, 0, 1, 1, 1), 0, 0, 0, 3'b000);
    send("R5 amr not for partition", mk(0, 0, 1, 1, 1, 1, 1), 1, 0, 1, 3'b000);
    // R6 protection faults
    send("R6 store no write", mk(0, 0, 1, 0, 1, 1, 1), 1, 1, 0, 3'b111);
    send("R6 fetch no exec", mk(0, 0, 1, 1, 0, 1, 1), 2, 1, 0, 3'b111);
    send("R6 rsvd as load", mk(0, 0, 0, 1, 1, 1, 1), 3, 1, 0, 3'b111);
    // R7 reference/change
    send("R7 store no change", mk(0, 0, 1, 1, 1, 1, 0), 1, 1, 0, 3'b111);
    send("R7 store no ref", mk(0, 0, 1, 1, 1, 0, 1), 1, 1, 0, 3'b111);
    send("R7 load ref only", mk(0, 0, 1, 0, 0, 1, 0), 0, 1, 0, 3'b000);
    send("R7 fetch no ref", mk(1, 0, 0, 0, 1, 0, 1), 2, 1, 0, 3'b000);
    // R9 clean accesses
    send("R9 clean store", mk(2, 0, 1, 1, 0, 1, 1), 1, 1, 1, 3'b000);
    send("R9 clean fetch", mk(0, 0, 0, 0, 1, 1, 0), 2, 0, 0, 3'b001);
    idle("R2 idle end");
    idle("R2 idle 2");

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 5) == 0) begin
        idle("R2 random idle");
      end else begin
        send("R3..R9 random", {$urandom, $urandom}, 2'($urandom), 1'($urandom),
             1'($urandom), 3'($urandom));
      end
    end
    idle("drain");
    idle("drain");
    run_chk = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule